// File: doc/BRIEF.md
# Paired-Difference Correlation Threshold Tester

This block scores one candidate location against one matching template. The template gives 40 test-point pairs (P, Q), each point 4 bits wide. Pairs 1 to 20 form the lead half and pairs 21 to 40 form the tail half. Each transfer carries one lead pair and one tail pair together, so a template takes 20 transfers. The block keeps three running sums. The lead sum adds |P − Q| over the lead half. The tail sum adds |P − Q| over the tail half. The square sum adds (P − Q)² over all 40 pairs.

After the 20th transfer, a five-stage integer pipeline forms two values:

- the spread SM = 40·(square sum) − (lead + tail)²
- the squared lead-over-tail margin

The candidate passes when the lead sum beats the tail sum and 400·(lead − tail)² ≥ 81·SM. This is the squared, cross-multiplied form of a correlation threshold of 0.45, so the block needs no divider and no square root.

The result appears exactly five clocks after the final transfer. A host can therefore read it after a fixed wait, with no handshake. A clear input starts a new template.

Top module: `pdc_corr_tester`

## Requirements
- R1: After an asynchronous reset, done_o and pass_o are 0.
- R2: Each pair contributes |P − Q| to its half's sum and (P − Q)² to the square sum, the same whether P is above or below Q.
- R3: The spread is SM = 40·S2 − (A + B)², where A is the lead sum (pairs 1..20), B is the tail sum (pairs 21..40) and S2 is the square sum. All of it is computed in exact integers with no overflow for any 4-bit inputs.
- R4: pass_o is 1 exactly when A > B and 400·(A − B)² ≥ 81·SM. Equality passes.
- R5: When SM is 0, pass_o is 0.
- R6: Number the clock edges so that the 20th accepted transfer is sampled at edge k. Then done_o is 0 after edges k+1 to k+4, and it rises after edge k+5 with pass_o valid in the same cycle.
- R7: Once 20 transfers have been accepted, further transfers are ignored until clear_i. done_o and pass_o hold their values.
- R8: clear_i zeroes all sums and the transfer count, and it drops done_o and pass_o on the next edge. A transfer presented in the same cycle as clear_i is discarded.
- R9: Idle cycles between transfers (pair_valid_i low) do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Start a new template; clears sums and result |
| pair_valid_i | input | 1 | A lead/tail pair couple is present this cycle |
| lead_p_i | input | 4 | P of the lead-half pair (pairs 1..20) |
| lead_q_i | input | 4 | Q of the lead-half pair |
| tail_p_i | input | 4 | P of the tail-half pair (pairs 21..40) |
| tail_q_i | input | 4 | Q of the tail-half pair |
| pass_o | output | 1 | Candidate passes the threshold; valid while done_o is 1 |
| done_o | output | 1 | Result valid; held until clear_i |

## Verification
The bench builds a template that sits exactly on the threshold, with 400·18² = 81·1600. A design that used a strict comparison there would reject it. It also builds a near neighbour just below the threshold, which an off-by-one on the constants would let through.

It feeds templates with uniform differences so that SM is 0. A design that skipped the zero-spread check, or mixed up the two halves, would report a pass there. It drives negative P − Q, which catches a signed or unsigned slip in the absolute value.

It checks the output one cycle before and at the fifth edge, to catch a pipeline that is one stage too short or too long. It sends extra transfers after completion, clears partway through a template, and asserts clear together with a transfer. In those cases a design that leaked stale or ignored data into the sums would give a result that differs from the bench's own integer model.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int unsigned PIPE_STAGES = 5;
  localparam int unsigned GAIN_MARGIN = 400;  // 400*(A-B)^2
  localparam int unsigned GAIN_SPREAD = 81;   // 81*SM ; 81/400 = 0.45^2
endpackage

// File: rtl/pdc_accum.sv
module pdc_accum #(
  parameter int unsigned PT_W   = 4,
  parameter int unsigned HALF_N = 20,
  parameter int unsigned SUM_W  = 9,
  parameter int unsigned SSQ_W  = 14,
  parameter int unsigned CNT_W  = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       pair_valid_i,
  input  logic [1:0][PT_W-1:0]       p_i,
  input  logic [1:0][PT_W-1:0]       q_i,
  output logic [SUM_W-1:0]           sum_lead_o,
  output logic [SUM_W-1:0]           sum_tail_o,
  output logic [SSQ_W-1:0]           ssq_o,
  output logic                       fin_o
);
  localparam int unsigned SQ_W = 2 * PT_W;

  logic [1:0][PT_W-1:0] ad;
  logic [1:0][SQ_W-1:0] sq;
  logic [CNT_W-1:0]     cnt;
  logic                 accept;

  // lane 0 feeds the lead sum, lane 1 the tail sum
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign ad[g] = (p_i[g] >= q_i[g]) ? (p_i[g] - q_i[g]) : (q_i[g] - p_i[g]);
    assign sq[g] = SQ_W'(ad[g]) * SQ_W'(ad[g]);
  end

  assign accept = pair_valid_i && !clear_i && (cnt != CNT_W'(HALF_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt        <= '0;
      sum_lead_o <= '0;
      sum_tail_o <= '0;
      ssq_o      <= '0;
      fin_o      <= 1'b0;
    end else if (clear_i) begin
      cnt        <= '0;
      sum_lead_o <= '0;
      sum_tail_o <= '0;
      ssq_o      <= '0;
      fin_o      <= 1'b0;
    end else begin
      fin_o <= accept && (cnt == CNT_W'(HALF_N - 1));
      if (accept) begin
        cnt        <= cnt + 1'b1;
        sum_lead_o <= sum_lead_o + SUM_W'(ad[0]);
        sum_tail_o <= sum_tail_o + SUM_W'(ad[1]);
        ssq_o      <= ssq_o + SSQ_W'(sq[0]) + SSQ_W'(sq[1]);
      end
    end
  end
endmodule

// File: rtl/pdc_decide.sv
module pdc_decide
  import pdc_pkg::*;
#(
  parameter int unsigned SUM_W = 9,
  parameter int unsigned SSQ_W = 14,
  parameter int unsigned CMP_W = 30,
  parameter int unsigned NPAIR = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic [SUM_W-1:0] sum_lead_i,
  input  logic [SUM_W-1:0] sum_tail_i,
  input  logic [SSQ_W-1:0] ssq_i,
  output logic             done_o,
  output logic             pass_o
);
  localparam int unsigned NV = PIPE_STAGES - 1;

  logic [NV:1]      v;
  logic [NV:1]      gt;
  logic [CMP_W-1:0] sum1, dif1, ss40_1;
  logic [CMP_W-1:0] sumsq2, difsq2, ss40_2;
  logic [CMP_W-1:0] spr3, mar3;
  logic [CMP_W-1:0] spr4, mar4;
  logic             sprz4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v <= '0; gt <= '0;
      sum1 <= '0; dif1 <= '0; ss40_1 <= '0;
      sumsq2 <= '0; difsq2 <= '0; ss40_2 <= '0;
      spr3 <= '0; mar3 <= '0;
      spr4 <= '0; mar4 <= '0; sprz4 <= 1'b0;
      done_o <= 1'b0; pass_o <= 1'b0;
    end else if (clear_i) begin
      v <= '0;
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      // stage 1: total, lead margin, 40*S2
      v[1]   <= start_i;
      gt[1]  <= sum_lead_i > sum_tail_i;
      sum1   <= CMP_W'(sum_lead_i) + CMP_W'(sum_tail_i);
      dif1   <= (sum_lead_i > sum_tail_i) ? CMP_W'(sum_lead_i - sum_tail_i) : '0;
      ss40_1 <= CMP_W'(ssq_i) * CMP_W'(NPAIR);
      // stage 2: squares
      v[2]   <= v[1];
      gt[2]  <= gt[1];
      sumsq2 <= sum1 * sum1;
      difsq2 <= dif1 * dif1;
      ss40_2 <= ss40_1;
      // stage 3: spread (never negative) and scaled margin
      v[3]   <= v[2];
      gt[3]  <= gt[2];
      spr3   <= ss40_2 - sumsq2;
      mar3   <= difsq2 * CMP_W'(GAIN_MARGIN);
      // stage 4: scaled spread
      v[4]   <= v[3];
      gt[4]  <= gt[3];
      spr4   <= spr3 * CMP_W'(GAIN_SPREAD);
      sprz4  <= spr3 == '0;
      mar4   <= mar3;
      // stage 5: decision, held until clear
      if (v[NV]) begin
        done_o <= 1'b1;
        pass_o <= gt[NV] && !sprz4 && (mar4 >= spr4);
      end
    end
  end
endmodule

// File: rtl/pdc_corr_tester.sv
module pdc_corr_tester #(
  parameter int unsigned PT_W   = 4,
  parameter int unsigned HALF_N = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            pair_valid_i,
  input  logic [PT_W-1:0] lead_p_i,
  input  logic [PT_W-1:0] lead_q_i,
  input  logic [PT_W-1:0] tail_p_i,
  input  logic [PT_W-1:0] tail_q_i,
  output logic            pass_o,
  output logic            done_o
);
  localparam int unsigned NPAIR  = 2 * HALF_N;
  localparam int unsigned DMAX   = (1 << PT_W) - 1;
  localparam int unsigned SUM_W  = $clog2(HALF_N * DMAX + 1);
  localparam int unsigned SSQ_W  = $clog2(NPAIR * DMAX * DMAX + 1);
  localparam int unsigned CNT_W  = $clog2(HALF_N + 1);
  // 400*(A-B)^2 and 40*S2*81 both fit with margin
  localparam int unsigned CMP_W  = 2 * (SUM_W + 1) + 10;

  logic [SUM_W-1:0] sum_lead, sum_tail;
  logic [SSQ_W-1:0] ssq;
  logic             fin;

  pdc_accum #(
    .PT_W(PT_W), .HALF_N(HALF_N), .SUM_W(SUM_W), .SSQ_W(SSQ_W), .CNT_W(CNT_W)
  ) u_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .pair_valid_i(pair_valid_i),
    .p_i         ({tail_p_i, lead_p_i}),
    .q_i         ({tail_q_i, lead_q_i}),
    .sum_lead_o  (sum_lead),
    .sum_tail_o  (sum_tail),
    .ssq_o       (ssq),
    .fin_o       (fin)
  );

  pdc_decide #(
    .SUM_W(SUM_W), .SSQ_W(SSQ_W), .CMP_W(CMP_W), .NPAIR(NPAIR)
  ) u_decide (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .start_i   (fin),
    .sum_lead_i(sum_lead),
    .sum_tail_i(sum_tail),
    .ssq_i     (ssq),
    .done_o    (done_o),
    .pass_o    (pass_o)
  );
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic clear_i,
  input logic fin_i,
  input logic done_i,
  input logic pass_i
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!done_i && !pass_i));

  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(fin_i, 5));

  a_r6_not_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |-> !done_i);

  a_r4_pass_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_i |-> done_i);

  a_r8_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!done_i && !pass_i));

  a_r7_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !clear_i) |=> (done_i && $stable(pass_i)));
endmodule

bind pdc_corr_tester pdc_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clear_i(clear_i),
  .fin_i  (fin),
  .done_i (done_o),
  .pass_i (pass_o)
);

// File: tb/pdc_corr_tester_bench.sv
`timescale 1ns/1ps
module pdc_corr_tester_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic       pair_valid_i = 1'b0;
  logic [3:0] lead_p_i = '0, lead_q_i = '0, tail_p_i = '0, tail_q_i = '0;
  logic       pass_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] tp [40];
  logic [3:0] tq [40];
  int unsigned rng = 32'h1234_5678;

  always #2.5 clk_i = ~clk_i;

  pdc_corr_tester u_pdc_corr_tester (.*);

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  function automatic int unsigned nxt();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  function automatic logic model_pass();
    int a = 0, b = 0, s2 = 0, d, spread;
    for (int i = 0; i < 40; i++) begin
      d = int'(tp[i]) - int'(tq[i]);
      if (d < 0) d = -d;
      if (i < 20) a += d; else b += d;
      s2 += d * d;
    end
    spread = 40 * s2 - (a + b) * (a + b);
    if (spread == 0) return 1'b0;
    return (a > b) && (400 * (a - b) * (a - b) >= 81 * spread);
  endfunction

  task automatic fill(input int lp, input int lq, input int rp, input int rq);
    for (int i = 0; i < 20; i++) begin
      tp[i] = 4'(lp); tq[i] = 4'(lq); tp[20+i] = 4'(rp); tq[20+i] = 4'(rq);
    end
  endtask

  task automatic do_clear();
    @(negedge clk_i); clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
  endtask

  task automatic drive(input int t);
    pair_valid_i = 1'b1;
    lead_p_i = tp[t]; lead_q_i = tq[t]; tail_p_i = tp[20+t]; tail_q_i = tq[20+t];
  endtask

  // sends 20 transfers, checks R6 timing and result against the model
  task automatic run(input string req, input string what, input int gap);
    logic exp = model_pass();
    for (int t = 0; t < 20; t++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk_i); pair_valid_i = 1'b0;
      end
      @(negedge clk_i); drive(t);
    end
    @(negedge clk_i); pair_valid_i = 1'b0;     // after edge k
    repeat (4) @(negedge clk_i);                // after edge k+4
    chk(done_o, 1'b0, "R6", {what, " done before 5th edge"});
    @(negedge clk_i);                           // after edge k+5
    chk(done_o, 1'b1, "R6", {what, " done at 5th edge"});
    chk(pass_o, exp, req, {what, " pass"});
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(done_o, 1'b0, "R1", "done in reset");
    chk(pass_o, 1'b0, "R1", "pass in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o, 1'b0, "R1", "done after reset");
  endtask

  task automatic t_zero_spread();
    do_clear(); fill(5, 5, 9, 9);   run("R5", "all equal", 0);
    chk(pass_o, 1'b0, "R5", "all equal spread 0");
    do_clear(); fill(3, 6, 10, 7);  run("R5", "uniform diff 3", 0);
    chk(pass_o, 1'b0, "R5", "uniform diff spread 0");
  endtask

  task automatic t_main();
    do_clear(); fill(15, 0, 7, 7);  run("R4", "strong lead", 0);
    chk(pass_o, 1'b1, "R4", "strong lead expected pass");
    do_clear(); fill(0, 15, 2, 2);  run("R2", "negative diffs", 0);
    chk(pass_o, 1'b1, "R2", "abs of P<Q");
    do_clear(); fill(4, 4, 0, 15);  run("R4", "tail dominates", 0);
    chk(pass_o, 1'b0, "R4", "tail dominates expected fail");
  endtask

  // A=19 B=1 S2=50: SM=1600, 400*18^2 == 81*1600
  task automatic t_boundary();
    fill(0, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin tp[i] = 4'd0; tq[i] = 4'd3; end
    for (int i = 5; i < 9; i++) begin tp[i] = 4'd8; tq[i] = 4'd7; end
    tp[20] = 4'd1;
    do_clear(); run("R4", "exact threshold", 0);
    chk(pass_o, 1'b1, "R3", "equality passes");
    tp[21] = 4'd1;                    // B=2 -> just below
    do_clear(); run("R4", "just below threshold", 0);
    chk(pass_o, 1'b0, "R3", "just below fails");
  endtask

  task automatic t_random();
    for (int n = 0; n < 10; n++) begin
      int unsigned bias = nxt() % 3;
      for (int i = 0; i < 40; i++) begin
        tp[i] = 4'(nxt());
        tq[i] = (bias == 0 && i < 20) ? 4'(int'(tp[i]) / 3) :
                (bias == 1) ? 4'(int'(tp[i]) ^ int'(nxt() % 2)) : 4'(nxt());
      end
      do_clear(); run("R3", "random template", n % 3);  // R9 gaps
    end
  endtask

  task automatic t_extra();
    logic held;
    do_clear(); fill(15, 0, 3, 3); run("R4", "before extras", 2);
    held = pass_o;
    fill(0, 0, 0, 15);
    for (int t = 0; t < 6; t++) begin @(negedge clk_i); drive(t); end
    @(negedge clk_i); pair_valid_i = 1'b0;
    repeat (6) @(negedge clk_i);
    chk(done_o, 1'b1, "R7", "done held after extras");
    chk(pass_o, held, "R7", "pass held after extras");
  endtask

  task automatic t_clear();
    do_clear();
    chk(done_o, 1'b0, "R8", "done dropped by clear");
    chk(pass_o, 1'b0, "R8", "pass dropped by clear");
    fill(0, 0, 15, 0);                 // junk partial template
    for (int t = 0; t < 10; t++) begin @(negedge clk_i); drive(t); end
    @(negedge clk_i); clear_i = 1'b1;  // clear with a transfer present
    @(negedge clk_i); clear_i = 1'b0; pair_valid_i = 1'b0;
    fill(12, 1, 6, 6);
    run("R8", "after mid clear", 0);
    chk(pass_o, 1'b1, "R8", "stale sums discarded");
  endtask

  initial begin
    t_reset();
    t_zero_spread();
    t_main();
    t_boundary();
    t_random();
    t_extra();
    t_clear();
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule